// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block brings a DDR2 memory from reset to its operating state. A single-cycle start pulse launches the sequence. The block first writes two configuration words that switch on the PHY delay-locked loop, then waits for the PHY to report lock. A lock timeout guards that wait. Next the block counts out the power-up hold-off with the clock running. It then steps through a fixed list of thirteen memory commands on a command port. After each command it waits for the port's busy flag to clear, and it inserts a settle gap after the steps that need one.

The mode-register command word is built from the CAS latency and write-recovery inputs. Every delay is a cycle count derived from a clock-frequency parameter, so a simulation can shrink it. When the last command has completed its handshake, `done` rises and stays high. If lock never arrives, `lock_err` rises and the sequence halts.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: After a synchronous reset, `phy_wr`, `cmd_valid`, `done` and `lock_err` are low and both output words are zero.
- R2: A start pulse in the idle state produces two single-cycle `phy_wr` pulses on consecutive cycles. The first carries `phy_word` 0x00022828 (DLL on, start point and increment 0x28). The second carries 0x00032828 (the same with the start bit set).
- R3: Lock means both bits of `phy_status[1:0]` are 1; a single set bit is not lock. If lock is not seen within LOCK_TMO cycles of the second PHY write, `lock_err` rises and stays high, and no command is ever issued.
- R4: The first command is issued no sooner than PWRUP_US*CLK_MHZ cycles after lock is presented.
- R5: Thirteen commands are issued in this order, as `cmd_word` values: wake-up 0x10000000; NOP 0x20000000; precharge-all 0x30000000; EMR2 0x80220000; EMR3 0x80230000; EMR1 0x80210006 (75-ohm termination, reduced drive, DLL enabled); MR with DLL reset; precharge-all; refresh 0x40000000; refresh; MR without DLL reset; EMR1 plus calibration default 0x80210386; EMR1 calibration exit 0x80210006.
- R6: The MR word is 0x80200003 + CL*16 + (WR-1)*512, which selects burst length 8. The base is 0x80200002 when SDR_MODE is 1. The DLL-reset variant adds 0x100 (bit 8).
- R7: Each command is a one-cycle `cmd_valid` pulse. `cmd_busy` is ignored in the first cycle after the pulse and sampled from the second cycle on. When busy is low and no gap follows, the next pulse comes two cycles after busy is first sampled low, so consecutive pulses are L+3 cycles apart for a busy lasting L cycles.
- R8: After the EMR1 write, both MR writes, the second precharge-all and both refreshes, a gap of GAP_US*CLK_MHZ cycles is added, making the pulse spacing L+4+GAP.
- R9: `done` rises two cycles after the last command's pulse plus the busy time. It stays high, and later start pulses then produce no PHY writes and no commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cas_lat | input | 4 | CAS latency for the MR word |
| wr_recov | input | 4 | Write recovery for the MR word |
| phy_status | input | 2 | PHY lock pair, lock when both set |
| cmd_busy | input | 1 | Command port busy flag |
| phy_word | output | 32 | PHY DLL configuration word |
| phy_wr | output | 1 | Strobe for `phy_word` |
| cmd_word | output | 32 | Memory command word |
| cmd_valid | output | 1 | Strobe for `cmd_word` |
| done | output | 1 | Sequence complete |
| lock_err | output | 1 | Lock timeout, sequence halted |

## Verification
The bench builds the block with CLK_MHZ=2 and LOCK_TMO=60. This gives a 400-cycle power-up hold-off and a 2-cycle settle gap. With these values two full bring-ups, a lock timeout and a late-lock check all fit in a short run. The short delays make it practical to check exact pulse spacing for every step, under two different busy lengths and two CL/WR pairs.

// File: rtl/ddr2_seq_pkg.sv
`timescale 1ns/1ps
package ddr2_seq_pkg;
  localparam int PARAM_W   = 4;
  localparam int NUM_STEPS = 13;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  localparam logic [31:0] PHY_DLL_ON    = 32'h0002_2828;
  localparam logic [31:0] PHY_DLL_START = 32'h0003_2828;

  localparam logic [31:0] CW_WAKE  = 32'h1000_0000;
  localparam logic [31:0] CW_NOP   = 32'h2000_0000;
  localparam logic [31:0] CW_PREA  = 32'h3000_0000;
  localparam logic [31:0] CW_REF   = 32'h4000_0000;
  localparam logic [31:0] CW_EMR2  = 32'h8022_0000;
  localparam logic [31:0] CW_EMR3  = 32'h8023_0000;
  localparam logic [31:0] CW_EMR1  = 32'h8021_0006;
  localparam logic [31:0] OCD_DFLT = 32'h0000_0380;
  localparam logic [31:0] DLL_RST  = 32'h0000_0100;

  typedef enum logic [3:0] {
    S_IDLE, S_PHY2, S_LOCKW, S_PWRUP, S_ISSUE, S_BUSYW, S_GAP, S_DONE, S_ERR
  } seq_state_t;
endpackage

// File: rtl/ddr2_seq_timer.sv
`timescale 1ns/1ps
module ddr2_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ddr2_seq_rom.sv
`timescale 1ns/1ps
module ddr2_seq_rom
  import ddr2_seq_pkg::*;
#(
  parameter bit SDR_MODE = 1'b0
) (
  input  logic [STEP_W-1:0]  step,
  input  logic [PARAM_W-1:0] cas_lat,
  input  logic [PARAM_W-1:0] wr_recov,
  output logic [31:0]        word,
  output logic               gap_after,
  output logic               last
);
  logic [31:0] mr_base;
  logic [31:0] mr_word;

  generate
    if (SDR_MODE) begin : g_sdr
      assign mr_base = 32'h8020_0002;
    end else begin : g_ddr2
      assign mr_base = 32'h8020_0003;
    end
  endgenerate

  assign mr_word = mr_base + (32'(cas_lat) << 4) + ((32'(wr_recov) - 32'd1) << 9);

  always_comb begin
    word      = CW_NOP;
    gap_after = 1'b0;
    case (step)
      4'd0:  word = CW_WAKE;
      4'd1:  word = CW_NOP;
      4'd2:  word = CW_PREA;
      4'd3:  word = CW_EMR2;
      4'd4:  word = CW_EMR3;
      4'd5:  begin word = CW_EMR1;            gap_after = 1'b1; end
      4'd6:  begin word = mr_word + DLL_RST;  gap_after = 1'b1; end
      4'd7:  begin word = CW_PREA;            gap_after = 1'b1; end
      4'd8:  begin word = CW_REF;             gap_after = 1'b1; end
      4'd9:  begin word = CW_REF;             gap_after = 1'b1; end
      4'd10: begin word = mr_word;            gap_after = 1'b1; end
      4'd11: word = CW_EMR1 | OCD_DFLT;
      4'd12: word = CW_EMR1;
      default: word = CW_NOP;
    endcase
  end

  assign last = (step == STEP_W'(NUM_STEPS - 1));
endmodule

// File: rtl/ddr2_bringup_seq.sv
`timescale 1ns/1ps
module ddr2_bringup_seq
  import ddr2_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 400,
  parameter int PWRUP_US = 200,
  parameter int GAP_US   = 1,
  parameter int LOCK_TMO = 1000000,
  parameter bit SDR_MODE = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [PARAM_W-1:0] cas_lat,
  input  logic [PARAM_W-1:0] wr_recov,
  input  logic [1:0]         phy_status,
  input  logic               cmd_busy,
  output logic [31:0]        phy_word,
  output logic               phy_wr,
  output logic [31:0]        cmd_word,
  output logic               cmd_valid,
  output logic               done,
  output logic               lock_err
);
  localparam int PWRUP_CYC = PWRUP_US * CLK_MHZ;
  localparam int GAP_CYC   = GAP_US * CLK_MHZ;
  localparam int MAX_A     = (PWRUP_CYC > LOCK_TMO) ? PWRUP_CYC : LOCK_TMO;
  localparam int MAX_V     = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CNT_W     = $clog2(MAX_V + 1);

  seq_state_t        st;
  logic [STEP_W-1:0] step;
  logic              busy_skip;
  logic              locked;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic [31:0]       rom_word;
  logic              rom_gap;
  logic              rom_last;
  logic              cmd_clear;

  assign locked    = &phy_status;
  assign cmd_clear = (st == S_BUSYW) && !busy_skip && !cmd_busy;

  ddr2_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  ddr2_seq_rom #(.SDR_MODE(SDR_MODE)) u_rom (
    .step(step), .cas_lat(cas_lat), .wr_recov(wr_recov),
    .word(rom_word), .gap_after(rom_gap), .last(rom_last)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      S_PHY2:  begin tmr_load = 1'b1; tmr_val = CNT_W'(LOCK_TMO); end
      S_LOCKW: if (locked) begin tmr_load = 1'b1; tmr_val = CNT_W'(PWRUP_CYC); end
      S_BUSYW: if (cmd_clear && rom_gap) begin tmr_load = 1'b1; tmr_val = CNT_W'(GAP_CYC); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      step      <= '0;
      busy_skip <= 1'b0;
      phy_word  <= '0;
      phy_wr    <= 1'b0;
      cmd_word  <= '0;
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      lock_err  <= 1'b0;
    end else begin
      phy_wr    <= 1'b0;
      cmd_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          phy_word <= PHY_DLL_ON;
          phy_wr   <= 1'b1;
          step     <= '0;
          st       <= S_PHY2;
        end
        S_PHY2: begin
          phy_word <= PHY_DLL_START;
          phy_wr   <= 1'b1;
          st       <= S_LOCKW;
        end
        S_LOCKW: begin
          if (locked) st <= S_PWRUP;
          else if (tmr_exp) begin
            lock_err <= 1'b1;
            st       <= S_ERR;
          end
        end
        S_PWRUP: if (tmr_exp) st <= S_ISSUE;
        S_ISSUE: begin
          cmd_word  <= rom_word;
          cmd_valid <= 1'b1;
          busy_skip <= 1'b1;
          st        <= S_BUSYW;
        end
        S_BUSYW: begin
          busy_skip <= 1'b0;
          if (cmd_clear) begin
            if (rom_gap) st <= S_GAP;
            else if (rom_last) begin
              done <= 1'b1;
              st   <= S_DONE;
            end else begin
              step <= step + 1'b1;
              st   <= S_ISSUE;
            end
          end
        end
        S_GAP: if (tmr_exp) begin
          step <= step + 1'b1;
          st   <= S_ISSUE;
        end
        S_DONE:  ;
        S_ERR:   ;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr2_seq_chk.sv
`timescale 1ns/1ps
module ddr2_seq_chk (
  input logic clk,
  input logic rst,
  input logic phy_wr,
  input logic cmd_valid,
  input logic cmd_busy,
  input logic done,
  input logic lock_err
);
  // R7: command strobe is a single-cycle pulse
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R7: no new command while the port reported busy in the cycle before
  a_r7_not_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(!cmd_busy));
  // R9: done is sticky
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R3: timeout flag is sticky and silences the command port
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_err |=> (lock_err && !cmd_valid));
  // R3/R9: completion and timeout are exclusive
  a_r3_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && lock_err));
  // R2: PHY writes never overlap command strobes
  a_r2_phy_sep: assert property (@(posedge clk) disable iff (rst)
    phy_wr |-> !cmd_valid);
endmodule

bind ddr2_bringup_seq ddr2_seq_chk u_chk (
  .clk(clk), .rst(rst), .phy_wr(phy_wr), .cmd_valid(cmd_valid),
  .cmd_busy(cmd_busy), .done(done), .lock_err(lock_err)
);

// File: tb/ddr2_bringup_seq_test.sv
`timescale 1ns/1ps
module ddr2_bringup_seq_test;
  localparam int MHZ  = 2;
  localparam int TMO  = 60;
  localparam int PWR  = 200 * MHZ;
  localparam int GAPC = MHZ;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [3:0] cas_lat = 4'd6, wr_recov = 4'd6;
  logic [1:0] phy_status = 2'b00;
  logic cmd_busy;
  logic [31:0] phy_word, cmd_word;
  logic phy_wr, cmd_valid, done, lock_err;

  int nchk = 0, nfail = 0, cyc = 0, busy_len = 0, bcnt = 0;
  logic [31:0] wlog [0:31];
  int clog [0:31];
  logic [31:0] plog [0:7];
  int pcyc [0:7];
  int nw = 0, np = 0, done_cyc = -1;

  ddr2_bringup_seq #(.CLK_MHZ(MHZ), .LOCK_TMO(TMO)) uut (
    .clk(clk), .rst(rst), .start(start), .cas_lat(cas_lat), .wr_recov(wr_recov),
    .phy_status(phy_status), .cmd_busy(cmd_busy), .phy_word(phy_word), .phy_wr(phy_wr),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid), .done(done), .lock_err(lock_err)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst) bcnt <= 0;
    else if (cmd_valid) bcnt <= busy_len;
    else if (bcnt != 0) bcnt <= bcnt - 1;
  end
  assign cmd_busy = (bcnt != 0);

  always @(negedge clk) begin
    if (cmd_valid && nw < 32) begin wlog[nw] = cmd_word; clog[nw] = cyc; nw = nw + 1; end
    if (phy_wr && np < 8) begin plog[np] = phy_word; pcyc[np] = cyc; np = np + 1; end
    if (done && done_cyc < 0) done_cyc = cyc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int i, int cl, int wr);
    logic [31:0] mr = 32'h8020_0003 + 32'(cl * 16) + 32'((wr - 1) * 512);
    case (i)
      0: return 32'h1000_0000;
      1: return 32'h2000_0000;
      2, 7: return 32'h3000_0000;
      3: return 32'h8022_0000;
      4: return 32'h8023_0000;
      5, 12: return 32'h8021_0006;
      6: return mr + 32'h100;
      8, 9: return 32'h4000_0000;
      10: return mr;
      default: return 32'h8021_0386;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start = 1'b0; phy_status = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nw = 0; np = 0; done_cyc = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check(!phy_wr && !cmd_valid && !done && !lock_err, "R1", "control outputs after reset",
          {phy_wr, cmd_valid, done, lock_err}, 0);
    check(phy_word == 0 && cmd_word == 0, "R1", "words after reset", cmd_word | phy_word, 0);
  endtask

  task automatic t_bringup(input int cl, input int wr, input int blen);
    int lock_cyc;
    do_reset();
    cas_lat = 4'(cl); wr_recov = 4'(wr); busy_len = blen;
    pulse_start();
    repeat (5) @(negedge clk);
    check(np == 2, "R2", "phy write count", np, 2);
    check(plog[0] == 32'h0002_2828, "R2", "first phy word", plog[0], 32'h0002_2828);
    check(plog[1] == 32'h0003_2828, "R2", "second phy word", plog[1], 32'h0003_2828);
    check(pcyc[1] == pcyc[0] + 1, "R2", "phy writes consecutive", pcyc[1] - pcyc[0], 1);
    repeat (10) @(negedge clk);
    phy_status = 2'b11; lock_cyc = cyc;
    for (int k = 0; k < 3000 && done_cyc < 0; k++) @(negedge clk);
    check(nw == 13, "R5", "command count", nw, 13);
    if (nw == 13) begin
      check(clog[0] - lock_cyc >= PWR && clog[0] - lock_cyc <= PWR + 5, "R4",
            "power-up hold-off", clog[0] - lock_cyc, PWR);
      for (int i = 0; i < 13; i++)
        check(wlog[i] == exp_word(i, cl, wr), (i == 6 || i == 10) ? "R6" : "R5",
              $sformatf("command %0d word", i), wlog[i], exp_word(i, cl, wr));
      for (int i = 0; i < 12; i++) begin
        int ex = (i >= 5 && i <= 10) ? blen + 4 + GAPC : blen + 3;
        check(clog[i+1] - clog[i] == ex, (i >= 5 && i <= 10) ? "R8" : "R7",
              $sformatf("spacing after command %0d", i), clog[i+1] - clog[i], ex);
      end
      check(done_cyc == clog[12] + blen + 2, "R9", "done timing", done_cyc, clog[12] + blen + 2);
    end
    check(!lock_err, "R3", "no error on normal run", lock_err, 0);
  endtask

  task automatic t_start_after_done();
    int nw0 = nw, np0 = np;
    pulse_start();
    repeat (30) @(negedge clk);
    check(nw == nw0 && np == np0, "R9", "start after done ignored", (nw - nw0) + (np - np0), 0);
    check(done, "R9", "done stays high", done, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    busy_len = 1;
    phy_status = 2'b10;
    pulse_start();
    repeat (TMO / 2) @(negedge clk);
    check(!lock_err, "R3", "no error before timeout", lock_err, 0);
    repeat (TMO) @(negedge clk);
    check(lock_err, "R3", "single status bit gives timeout", lock_err, 1);
    phy_status = 2'b11;
    repeat (PWR + 100) @(negedge clk);
    check(nw == 0 && !done, "R3", "late lock ignored after error", nw, 0);
    check(lock_err, "R3", "error sticky", lock_err, 1);
  endtask

  initial begin
    t_reset_state();
    t_bringup(6, 6, 3);
    t_start_after_done();
    t_bringup(4, 3, 0);
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule